// File: doc/BRIEF.md
# Binary Trigger-Wave Propagation Grid

This block is a rectangular grid of single-bit cells. Each cell talks only to its four nearest neighbours. It performs binary wave operations such as object reconstruction and hole filling. Every cell holds three things: a space bit that says whether the wave may enter the cell, a seed bit that gives its starting state, and four direction enables. The direction enables come from the low four bits of that cell's local bus. A cell inside the space turns on when any neighbour it listens to is on, and once on it stays on. A cell outside the space keeps its seed value, and it still offers that value to its neighbours.

A single `load_i` pulse captures the whole picture: space, seed and direction enables. It starts the wave at once. The wave front moves one cell per clock. When a full cycle passes in which no cell changes, the grid has reached its fixed point. `done_o` then rises and stays high, with the states frozen, until the next load.

Top module: `twave_array`

## Requirements
- R1: After reset, every bit of `cell_o` is 0 and `done_o` is 0.
- R2: On a clock edge with `load_i` high, each cell takes its seed bit from `seed_i` as its state. It also captures its space bit and its four direction bits. Changes to `space_i`, `seed_i` or `lbus_i` at any other time have no effect.
- R3: For cell i, the direction bits are `lbus_i[4i+3:4i]`. Bit 3 accepts the north neighbour (row r-1), bit 2 accepts the west neighbour (column c-1), bit 1 accepts the south neighbour (row r+1) and bit 0 accepts the east neighbour (column c+1). Cell i is at row r = i / COLS and column c = i % COLS.
- R4: A cell whose space bit is 1 and whose state is 1 keeps state 1 until the next load.
- R5: A cell whose space bit is 0 holds its seed value throughout a run. Its state is still seen by its neighbours.
- R6: Neighbour positions outside the grid read as inactive. There is no wrap-around.
- R7: While running, a cell in the space turns on exactly one clock after an accepted neighbour turns on. The state after k edges matches k synchronous update steps from the seed.
- R8: `done_o` rises on the first edge after a cycle in which no cell would change. It stays high, with `cell_o` stable, until the next load, and a load clears it.
- R9: A load during a run discards the current wave and restarts from the new seed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_i | input | 1 | Capture the cell configuration and start a run |
| space_i | input | ROWS*COLS | Space bit per cell; 1 = the wave may enter |
| seed_i | input | ROWS*COLS | Initial state per cell |
| lbus_i | input | 4*ROWS*COLS | Low bus nibble per cell; direction enables {N,W,S,E} |
| cell_o | output | ROWS*COLS | Present cell states, index r*COLS+c |
| done_o | output | 1 | Fixed point reached |

## Verification
A wrong stored direction bit or space bit shows up at `cell_o` on the very next clock. The mis-gated cell turns on one cycle early, or fails to turn on, and the error then spreads one cell per cycle after that. For this reason the bench compares the full state vector after every edge, not only the final picture. A broken settle detector shows as `done_o` rising while a cell still changes, or rising a cycle late. Each run therefore also checks the exact edge count from load to done against the reference model's step count.

// File: rtl/twave_pkg.sv
package twave_pkg;
    localparam int DIR_W  = 4;
    localparam int MASK_N = 3;
    localparam int MASK_W = 2;
    localparam int MASK_S = 1;
    localparam int MASK_E = 0;

    typedef struct packed {
        logic              space;
        logic              seed;
        logic [DIR_W-1:0]  mask;
        logic              state;
    } cell_reg_t;

    typedef struct packed {
        logic run;
        logic done;
    } settle_reg_t;
endpackage

// File: rtl/twave_cell.sv
module twave_cell
    import twave_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             run_i,
    input  logic             space_i,
    input  logic             seed_i,
    input  logic [DIR_W-1:0] mask_i,
    input  logic             nbr_n_i,
    input  logic             nbr_s_i,
    input  logic             nbr_w_i,
    input  logic             nbr_e_i,
    output logic             state_o,
    output logic             change_o
);
    cell_reg_t cell_d, cell_q;
    logic      pull;
    logic      grow;

    always_comb begin
        pull = (nbr_n_i & cell_q.mask[MASK_N]) | (nbr_w_i & cell_q.mask[MASK_W])
             | (nbr_s_i & cell_q.mask[MASK_S]) | (nbr_e_i & cell_q.mask[MASK_E]);
        grow = cell_q.space ? (cell_q.state | pull) : cell_q.seed;
        cell_d = cell_q;
        if (load_i) begin
            cell_d.space = space_i;
            cell_d.seed  = seed_i;
            cell_d.mask  = mask_i;
            cell_d.state = seed_i;
        end else if (run_i) begin
            cell_d.state = grow;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cell_q <= '0;
        else        cell_q <= cell_d;
    end

    assign state_o  = cell_q.state;
    assign change_o = run_i & (grow != cell_q.state);

    // R4
    active_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && cell_q.space && cell_q.state) |=> cell_q.state);

    // R5
    outside_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !cell_q.space) |=> $stable(cell_q.state));
endmodule

// File: rtl/twave_settle.sv
module twave_settle
    import twave_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    input  logic change_any_i,
    output logic run_o,
    output logic done_o
);
    settle_reg_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load_i) begin
            st_d.run  = 1'b1;
            st_d.done = 1'b0;
        end else if (st_q.run && !change_any_i) begin
            st_d.run  = 1'b0;
            st_d.done = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign run_o  = st_q.run;
    assign done_o = st_q.done;

    // R8
    quiet_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.run && !load_i && !change_any_i) |=> st_q.done);

    // R8
    busy_not_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.run && !load_i && change_any_i) |=> !st_q.done);

    // R9
    load_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (st_q.run && !st_q.done));
endmodule

// File: rtl/twave_array.sv
module twave_array
    import twave_pkg::*;
#(
    parameter int ROWS = 19,
    parameter int COLS = 22
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        load_i,
    input  logic [ROWS*COLS-1:0]        space_i,
    input  logic [ROWS*COLS-1:0]        seed_i,
    input  logic [DIR_W*ROWS*COLS-1:0]  lbus_i,
    output logic [ROWS*COLS-1:0]        cell_o,
    output logic                        done_o
);
    localparam int NCELL = ROWS * COLS;

    logic [NCELL-1:0] state_w;
    logic [NCELL-1:0] change_w;
    logic             run_w;
    logic             done_w;

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        for (genvar c = 0; c < COLS; c++) begin : g_col
            localparam int IDX = r * COLS + c;
            logic nn, ns, nw, ne;

            if (r > 0) begin : g_n
                assign nn = state_w[IDX-COLS];
            end else begin : g_n0
                assign nn = 1'b0;
            end
            if (r < ROWS-1) begin : g_s
                assign ns = state_w[IDX+COLS];
            end else begin : g_s0
                assign ns = 1'b0;
            end
            if (c > 0) begin : g_w
                assign nw = state_w[IDX-1];
            end else begin : g_w0
                assign nw = 1'b0;
            end
            if (c < COLS-1) begin : g_e
                assign ne = state_w[IDX+1];
            end else begin : g_e0
                assign ne = 1'b0;
            end

            twave_cell u_cell (
                .clk      (clk),
                .rst_n    (rst_n),
                .load_i   (load_i),
                .run_i    (run_w),
                .space_i  (space_i[IDX]),
                .seed_i   (seed_i[IDX]),
                .mask_i   (lbus_i[DIR_W*IDX +: DIR_W]),
                .nbr_n_i  (nn),
                .nbr_s_i  (ns),
                .nbr_w_i  (nw),
                .nbr_e_i  (ne),
                .state_o  (state_w[IDX]),
                .change_o (change_w[IDX])
            );
        end
    end

    twave_settle u_settle (
        .clk          (clk),
        .rst_n        (rst_n),
        .load_i       (load_i),
        .change_any_i (|change_w),
        .run_o        (run_w),
        .done_o       (done_w)
    );

    assign cell_o = state_w;
    assign done_o = done_w;

    // R8
    frozen_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !load_i) |=> (done_o && $stable(cell_o)));
endmodule

// File: tb/twave_array_tb_top.sv
`timescale 1ns/1ps
module twave_array_tb_top;
    localparam int R = 5;
    localparam int C = 7;
    localparam int N = R * C;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           load_i = 1'b0;
    logic [N-1:0]   space_i = '0;
    logic [N-1:0]   seed_i = '0;
    logic [4*N-1:0] lbus_i = '0;
    logic [N-1:0]   cell_o;
    logic           done_o;

    int total = 0;
    int bad = 0;

    logic [N-1:0]   sp, sd, ex, nx;
    logic [4*N-1:0] mk;

    always #4 clk = ~clk;

    twave_array #(.ROWS(R), .COLS(C)) dut_i (
        .clk(clk), .rst_n(rst_n), .load_i(load_i), .space_i(space_i),
        .seed_i(seed_i), .lbus_i(lbus_i), .cell_o(cell_o), .done_o(done_o)
    );

    task automatic check_vec(string req, string what, logic [N-1:0] act, logic [N-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic check_bit(string req, string what, logic act, logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    function automatic int idx(int r, int c);
        return r * C + c;
    endfunction

    // one synchronous update of the reference model; returns 1 if anything changes
    task automatic model_step(output bit chg);
        for (int r = 0; r < R; r++) begin
            for (int c = 0; c < C; c++) begin
                int  i = idx(r, c);
                bit  n = (r > 0)   ? ex[i-C] : 1'b0;
                bit  s = (r < R-1) ? ex[i+C] : 1'b0;
                bit  w = (c > 0)   ? ex[i-1] : 1'b0;
                bit  e = (c < C-1) ? ex[i+1] : 1'b0;
                bit  p = (n & mk[4*i+3]) | (w & mk[4*i+2]) | (s & mk[4*i+1]) | (e & mk[4*i]);
                nx[i] = sp[i] ? (ex[i] | p) : sd[i];
            end
        end
        chg = (nx != ex);
    endtask

    // load sp/sd/mk, follow the wave edge by edge, then check done timing
    task automatic run_case(string req, string name, bit scramble);
        bit chg;
        int steps = 0;
        @(negedge clk);
        space_i = sp; seed_i = sd; lbus_i = mk; load_i = 1'b1;
        @(negedge clk);
        load_i = 1'b0;
        if (scramble) begin
            space_i = ~sp; seed_i = ~sd; lbus_i = ~mk;
        end
        ex = sd;
        check_vec("R2", {name, " seed loaded"}, cell_o, ex);
        check_bit("R9", {name, " done cleared by load"}, done_o, 1'b0);
        forever begin
            model_step(chg);
            @(negedge clk);
            steps++;
            if (chg) begin
                ex = nx;
                check_vec("R7", {name, " per-edge state"}, cell_o, ex);
                check_bit("R8", {name, " done low while changing"}, done_o, 1'b0);
                if (steps > 4 * N) break;
            end else begin
                check_vec(req, {name, " final state"}, cell_o, ex);
                check_bit("R8", {name, " done at fixed point"}, done_o, 1'b1);
                break;
            end
        end
        @(negedge clk);
        check_bit("R8", {name, " done held"}, done_o, 1'b1);
        check_vec("R8", {name, " state frozen"}, cell_o, ex);
        space_i = '0; seed_i = '0; lbus_i = '0;
    endtask

    task automatic all_masks(logic [3:0] m);
        for (int i = 0; i < N; i++) mk[4*i +: 4] = m;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        check_vec("R1", "reset state", cell_o, '0);
        check_bit("R1", "reset done", done_o, 1'b0);
    endtask

    task automatic t_dir(logic [3:0] m, string name, logic [N-1:0] want);
        sp = '1; sd = '0; sd[idx(2, 3)] = 1'b1; all_masks(m);
        run_case("R3", name, 1'b0);
        check_vec("R3", {name, " explicit line"}, cell_o, want);
    endtask

    task automatic t_dirs();
        logic [N-1:0] w;
        w = '0; for (int r = 2; r < R; r++) w[idx(r, 3)] = 1'b1;
        t_dir(4'b1000, "north-accept spreads south", w);
        w = '0; for (int c = 3; c < C; c++) w[idx(2, c)] = 1'b1;
        t_dir(4'b0100, "west-accept spreads east", w);
        w = '0; for (int r = 0; r <= 2; r++) w[idx(r, 3)] = 1'b1;
        t_dir(4'b0010, "south-accept spreads north", w);
        w = '0; for (int c = 0; c <= 3; c++) w[idx(2, c)] = 1'b1;
        t_dir(4'b0001, "east-accept spreads west", w);
    endtask

    task automatic t_edges();
        sp = '1; sd = '0; all_masks(4'b1111);
        run_case("R6", "no seed, grid edges inactive", 1'b0);
        sp = '1; sd = '0; sd[idx(0, 0)] = 1'b1; all_masks(4'b1000);
        run_case("R6", "corner seed, no wrap", 1'b0);
        check_bit("R6", "top row beside corner stays off", cell_o[idx(0, 1)], 1'b0);
    endtask

    task automatic t_outside();
        sp = '1; sd = '0; all_masks(4'b1111);
        sp[idx(2, 3)] = 1'b0; sd[idx(2, 3)] = 1'b1;
        for (int c = 0; c < C; c++) sp[idx(4, c)] = 1'b0;
        run_case("R5", "outside seed drives neighbours", 1'b0);
        check_bit("R5", "outside seed kept", cell_o[idx(2, 3)], 1'b1);
        check_bit("R5", "outside zero cell not filled", cell_o[idx(4, 0)], 1'b0);
    endtask

    task automatic t_hole_fill();
        logic [N-1:0] obj;
        obj = '0;
        for (int c = 1; c <= 5; c++) begin obj[idx(1, c)] = 1'b1; obj[idx(3, c)] = 1'b1; end
        obj[idx(2, 1)] = 1'b1; obj[idx(2, 5)] = 1'b1;
        sp = ~obj; sd = '0; all_masks(4'b1111);
        for (int r = 0; r < R; r++)
            for (int c = 0; c < C; c++)
                if ((r == 0 || r == R-1 || c == 0 || c == C-1) && !obj[idx(r, c)]) sd[idx(r, c)] = 1'b1;
        run_case("R4", "hole filling", 1'b0);
        for (int c = 2; c <= 4; c++)
            check_bit("R4", "hole interior unreached", cell_o[idx(2, c)], 1'b0);
    endtask

    task automatic t_reconstruct();
        sp = '0;
        for (int r = 0; r < 3; r++) for (int c = 0; c < 3; c++) sp[idx(r, c)] = 1'b1;
        for (int r = 2; r < R; r++) sp[idx(r, 5)] = 1'b1;
        sd = '0; sd[idx(0, 0)] = 1'b1; all_masks(4'b1111);
        run_case("R4", "reconstruction", 1'b0);
        check_bit("R4", "unmarked object stays off", cell_o[idx(4, 5)], 1'b0);
        check_bit("R4", "marked object filled", cell_o[idx(2, 2)], 1'b1);
    endtask

    task automatic t_scramble();
        logic [31:0] lf = 32'h1ACE_B00C;
        for (int i = 0; i < N; i++) begin
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            sp[i] = lf[0] | lf[3];
            sd[i] = (lf[7:4] == 4'h0);
            mk[4*i +: 4] = lf[11:8] | 4'b0001;
        end
        run_case("R2", "inputs changed mid-run ignored", 1'b1);
    endtask

    task automatic t_reload();
        sp = '1; sd = '0; sd[idx(0, 0)] = 1'b1; all_masks(4'b1111);
        @(negedge clk);
        space_i = sp; seed_i = sd; lbus_i = mk; load_i = 1'b1;
        @(negedge clk);
        load_i = 1'b0;
        repeat (2) @(negedge clk);
        sd = '0; sd[idx(4, 6)] = 1'b1;
        run_case("R9", "reload during run", 1'b0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset();
        t_dirs();
        t_edges();
        t_outside();
        t_hole_fill();
        t_reconstruct();
        t_scramble();
        t_reload();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule